// File: doc/BRIEF.md
# Cycle-by-Cycle Current Fault Monitor

This block sits between the digitized current-sense comparators of a half-bridge lamp ballast controller and its mode sequencer. It receives two flags, one saying the sensed bridge current is above the programmed upper limit and one saying it is below the fixed lower limit. It also receives the present operating mode and a one-clock strobe marking each turn-off of the low-side switch. From these it decides whether a current fault has occurred.

The upper-limit check covers lamp failure to strike, excess current and hard switching. It is active in the ignition and run modes. The lower-limit check covers a missing load and operation below resonance. It is active only in run mode, and the lower flag is only looked at on the low-side turn-off strobe. Neither check is active during preheat or standby.

One violating clock is enough to raise the fault. The fault is latched together with a cause code. While the fault stands, the block tells the oscillator to stop and forces both gate drive outputs low. Only the sequencer's clear input releases the fault.

Top module: `cfm_top`

## Requirements
- R1: After reset `fault_req_o` is 0, `fault_cause_o` is 2'b00 and `osc_en_o` is 1.
- R2: Mode encoding on `mode_i` is 2'b00 standby, 2'b01 preheat, 2'b10 ignition and 2'b11 run. In standby and preheat, neither flag raises a fault, with or without the strobe.
- R3: In ignition or run with no fault held, `over_flag_i` high at a rising edge sets `fault_req_o` to 1 and `fault_cause_o` to 2'b01 right after that edge.
- R4: In run mode with no fault held, `under_flag_i` and `lo_fall_i` both high at the same rising edge set `fault_req_o` to 1 and `fault_cause_o` to 2'b10 right after that edge.
- R5: `under_flag_i` has no effect at an edge where `lo_fall_i` is low, and no effect in ignition mode even with the strobe.
- R6: When the upper and lower checks both trip at the same edge, the cause recorded is 2'b01.
- R7: Once raised, `fault_req_o` and the first cause stay unchanged until a clear, whatever the flags, strobe or mode do.
- R8: `clear_i` high at a rising edge makes `fault_req_o` 0 and `fault_cause_o` 2'b00 after that edge. It takes priority over a violation at the same edge.
- R9: While `fault_req_o` is 1, `osc_en_o` is 0 and `gate_o` is 2'b00. Otherwise `osc_en_o` is 1 and `gate_o` follows `gate_i` without delay (bit 1 high side, bit 0 low side).
- R10: A violation lasting a single clock is enough to raise the fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Present operating mode from the sequencer |
| over_flag_i | input | 1 | Sensed current above the upper limit |
| under_flag_i | input | 1 | Sensed current below the lower limit |
| lo_fall_i | input | 1 | One-clock strobe at low-side switch turn-off |
| clear_i | input | 1 | Sequencer request to drop the fault and cause |
| gate_i | input | 2 | Gate commands from the oscillator, bit 1 high side, bit 0 low side |
| gate_o | output | 2 | Gate commands after fault masking |
| osc_en_o | output | 1 | Oscillator enable, low while a fault stands |
| fault_req_o | output | 1 | Sticky fault request to the sequencer |
| fault_cause_o | output | 2 | Cause code: 2'b01 upper limit, 2'b10 lower limit, 2'b00 none |

## Verification
On every cycle, the assertions check the arming rules, the result one edge after each qualified violation, the stickiness of the cause, the priority of clear, and the masking of the gates and oscillator. They also check that every rise of the fault traces back to a detected violation. What only the bench scenarios can show is the full sequence across modes. This covers a fault taken in ignition and carried unchanged into run, a later violation of the other kind failing to overwrite the first cause, and the re-arming after clear, when a fresh pulse trips the block again.

// File: rtl/cfm_pkg.sv
package cfm_pkg;

  localparam int MODE_W  = 2;
  localparam int CAUSE_W = 2;
  localparam int GATE_N  = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_STANDBY = 2'b00,
    MODE_PREHEAT = 2'b01,
    MODE_IGNITE  = 2'b10,
    MODE_RUN     = 2'b11
  } op_mode_e;

  localparam logic [CAUSE_W-1:0] CAUSE_NONE  = 2'b00;
  localparam logic [CAUSE_W-1:0] CAUSE_OVER  = 2'b01;
  localparam logic [CAUSE_W-1:0] CAUSE_UNDER = 2'b10;

  // upper-limit check is live from the end of preheat onward
  function automatic logic over_armed(input op_mode_e m);
    return (m == MODE_IGNITE) || (m == MODE_RUN);
  endfunction

  // lower-limit check is live only once running
  function automatic logic under_armed(input op_mode_e m);
    return (m == MODE_RUN);
  endfunction

  // upper-limit trip outranks a simultaneous lower-limit trip
  function automatic logic [CAUSE_W-1:0] pick_cause(input logic hit_hi,
                                                     input logic hit_lo);
    if (hit_hi)      return CAUSE_OVER;
    else if (hit_lo) return CAUSE_UNDER;
    else             return CAUSE_NONE;
  endfunction

endpackage

// File: rtl/cfm_arm_decode.sv
module cfm_arm_decode
  import cfm_pkg::*;
(
  input  logic [MODE_W-1:0] mode_bits,
  output logic              arm_over,
  output logic              arm_under
);

  op_mode_e mode_e;

  always_comb begin
    mode_e    = op_mode_e'(mode_bits);
    arm_over  = over_armed(mode_e);
    arm_under = under_armed(mode_e);
  end

endmodule

// File: rtl/cfm_hit_detect.sv
module cfm_hit_detect
  import cfm_pkg::*;
(
  input  logic               arm_over,
  input  logic               arm_under,
  input  logic               over_flag,
  input  logic               under_flag,
  input  logic               lo_fall,
  output logic               hit_over,
  output logic               hit_under,
  output logic               hit_any,
  output logic [CAUSE_W-1:0] hit_cause
);

  always_comb begin
    hit_over  = arm_over & over_flag;
    // lower flag only counts at the low-side turn-off instant
    hit_under = arm_under & under_flag & lo_fall;
    hit_any   = hit_over | hit_under;
    hit_cause = pick_cause(hit_over, hit_under);
  end

endmodule

// File: rtl/cfm_fault_hold.sv
module cfm_fault_hold
  import cfm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               hit_any,
  input  logic [CAUSE_W-1:0] hit_cause,
  output logic               fault_q,
  output logic [CAUSE_W-1:0] cause_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else if (clear) begin
      fault_q <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else if (!fault_q && hit_any) begin
      fault_q <= 1'b1;
      cause_q <= hit_cause;
    end
  end

endmodule

// File: rtl/cfm_top.sv
module cfm_top
  import cfm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [MODE_W-1:0]  mode_i,
  input  logic               over_flag_i,
  input  logic               under_flag_i,
  input  logic               lo_fall_i,
  input  logic               clear_i,
  input  logic [GATE_N-1:0]  gate_i,
  output logic [GATE_N-1:0]  gate_o,
  output logic               osc_en_o,
  output logic               fault_req_o,
  output logic [CAUSE_W-1:0] fault_cause_o
);

  logic               arm_over;
  logic               arm_under;
  logic               hit_over;
  logic               hit_under;
  logic               hit_any;
  logic [CAUSE_W-1:0] hit_cause;
  logic               fault_q;
  logic [CAUSE_W-1:0] cause_q;

  cfm_arm_decode u_arm (
    .mode_bits (mode_i),
    .arm_over  (arm_over),
    .arm_under (arm_under)
  );

  cfm_hit_detect u_hit (
    .arm_over   (arm_over),
    .arm_under  (arm_under),
    .over_flag  (over_flag_i),
    .under_flag (under_flag_i),
    .lo_fall    (lo_fall_i),
    .hit_over   (hit_over),
    .hit_under  (hit_under),
    .hit_any    (hit_any),
    .hit_cause  (hit_cause)
  );

  cfm_fault_hold u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear_i),
    .hit_any   (hit_any),
    .hit_cause (hit_cause),
    .fault_q   (fault_q),
    .cause_q   (cause_q)
  );

  // each gate channel is masked by the held fault
  for (genvar g = 0; g < GATE_N; g++) begin : g_mask
    assign gate_o[g] = gate_i[g] & ~fault_q;
  end

  assign osc_en_o      = ~fault_q;
  assign fault_req_o   = fault_q;
  assign fault_cause_o = cause_q;

endmodule

// File: rtl/cfm_checker.sv
module cfm_checker
  import cfm_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [MODE_W-1:0]  mode_i,
  input logic               over_flag_i,
  input logic               under_flag_i,
  input logic               lo_fall_i,
  input logic               clear_i,
  input logic [GATE_N-1:0]  gate_i,
  input logic [GATE_N-1:0]  gate_o,
  input logic               osc_en_o,
  input logic               fault_req_o,
  input logic [CAUSE_W-1:0] fault_cause_o,
  input logic               hit_over,
  input logic               hit_under
);

  assert_quiet_modes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_req_o && !mode_i[1]) |=> !fault_req_o);

  assert_over_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_req_o && !clear_i && over_flag_i && mode_i[1])
      |=> (fault_req_o && fault_cause_o == 2'b01));

  assert_under_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_req_o && !clear_i && !over_flag_i && under_flag_i && lo_fall_i
      && mode_i == 2'b11) |=> (fault_req_o && fault_cause_o == 2'b10));

  assert_no_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_req_o && !over_flag_i && !lo_fall_i) |=> !fault_req_o);

  assert_single_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fault_req_o |-> ($countones(fault_cause_o) == 1));

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_req_o && !clear_i) |=> (fault_req_o && $stable(fault_cause_o)));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (!fault_req_o && fault_cause_o == 2'b00));

  assert_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_req_o |-> (gate_o == '0 && !osc_en_o));

  assert_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_req_o |-> (gate_o == gate_i && osc_en_o));

  assert_rise_traced_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_req_o) |-> $past(hit_over || hit_under));

endmodule

bind cfm_top cfm_checker u_cfm_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .mode_i        (mode_i),
  .over_flag_i   (over_flag_i),
  .under_flag_i  (under_flag_i),
  .lo_fall_i     (lo_fall_i),
  .clear_i       (clear_i),
  .gate_i        (gate_i),
  .gate_o        (gate_o),
  .osc_en_o      (osc_en_o),
  .fault_req_o   (fault_req_o),
  .fault_cause_o (fault_cause_o),
  .hit_over      (hit_over),
  .hit_under     (hit_under)
);

// File: tb/cfm_top_bench.sv
`timescale 1ns/1ps
module cfm_top_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic       over_flag_i = 1'b0;
  logic       under_flag_i = 1'b0;
  logic       lo_fall_i = 1'b0;
  logic       clear_i = 1'b0;
  logic [1:0] gate_i = 2'b00;
  logic [1:0] gate_o;
  logic       osc_en_o;
  logic       fault_req_o;
  logic [1:0] fault_cause_o;

  int    n_run = 0;
  int    n_fail = 0;
  bit    done = 0;
  string cur_req = "R1";

  // behavioural reference state
  bit       m_fault = 0;
  bit [1:0] m_cause = 0;

  always #10 clk = ~clk;

  cfm_top u_cfm_top (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .over_flag_i(over_flag_i),
    .under_flag_i(under_flag_i), .lo_fall_i(lo_fall_i), .clear_i(clear_i),
    .gate_i(gate_i), .gate_o(gate_o), .osc_en_o(osc_en_o),
    .fault_req_o(fault_req_o), .fault_cause_o(fault_cause_o)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check(cur_req, fault_req_o, m_fault, "fault_req");
    check(cur_req, fault_cause_o, m_cause, "cause");
    check(cur_req, osc_en_o, !m_fault, "osc_en");
    check(cur_req, gate_o, m_fault ? 0 : gate_i, "gate_o");
  endtask

  // one clock: drive at falling edge, check pass-through, step model, check after edge
  task automatic step(input bit [1:0] md, input bit ov, input bit un, input bit st,
                      input bit clr, input bit [1:0] gt);
    bit       nf;
    bit [1:0] nc;
    mode_i = md; over_flag_i = ov; under_flag_i = un; lo_fall_i = st;
    clear_i = clr; gate_i = gt;
    #1;
    compare_all();
    nf = m_fault; nc = m_cause;
    if (clr) begin nf = 0; nc = 0; end
    else if (!m_fault) begin
      if (ov && md >= 2) begin nf = 1; nc = 1; end
      else if (un && st && md == 3) begin nf = 1; nc = 2; end
    end
    @(negedge clk);
    m_fault = nf; m_cause = nc;
    compare_all();
  endtask

  task automatic idle(input bit [1:0] md, input int n);
    for (int i = 0; i < n; i++) step(md, 0, 0, 0, 0, 2'b11);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    check("R1", fault_req_o, 0, "fault in reset");
    check("R1", fault_cause_o, 0, "cause in reset");
    check("R1", osc_en_o, 1, "osc_en in reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();

    // R2: standby and preheat ignore every flag
    cur_req = "R2";
    step(2'b00, 1, 1, 1, 0, 2'b10);
    step(2'b01, 1, 0, 0, 0, 2'b01);
    step(2'b01, 0, 1, 1, 0, 2'b11);
    step(2'b01, 1, 1, 1, 0, 2'b00);
    check("R2", fault_req_o, 0, "preheat quiet");

    // R3 and R10: single-clock upper trip in ignition
    cur_req = "R3";
    idle(2'b10, 2);
    step(2'b10, 1, 0, 0, 0, 2'b11);
    check("R10", fault_req_o, 1, "one clock pulse trips");
    check("R3", fault_cause_o, 1, "upper cause 01");
    cur_req = "R9";
    step(2'b10, 0, 0, 0, 0, 2'b11);
    check("R9", gate_o, 0, "gates masked");
    check("R9", osc_en_o, 0, "osc stopped");
    cur_req = "R8";
    step(2'b10, 0, 0, 0, 1, 2'b11);
    check("R8", fault_cause_o, 0, "cleared cause");
    check("R9", gate_o, 3, "gates pass after clear");

    // R5: lower flag without strobe, and with strobe in ignition
    cur_req = "R5";
    step(2'b11, 0, 1, 0, 0, 2'b01);
    step(2'b11, 0, 1, 0, 0, 2'b10);
    step(2'b10, 0, 1, 1, 0, 2'b11);
    check("R5", fault_req_o, 0, "lower flag ignored");

    // R4: lower trip at strobe in run
    cur_req = "R4";
    step(2'b11, 0, 1, 1, 0, 2'b11);
    check("R4", fault_cause_o, 2, "lower cause 10");

    // R7: later upper trip and mode changes do not disturb the cause
    cur_req = "R7";
    step(2'b11, 1, 0, 0, 0, 2'b11);
    step(2'b10, 1, 1, 1, 0, 2'b11);
    step(2'b00, 0, 0, 0, 0, 2'b11);
    check("R7", fault_cause_o, 2, "first cause kept");
    cur_req = "R8";
    step(2'b11, 0, 0, 0, 1, 2'b00);

    // R6: both trips at one edge
    cur_req = "R6";
    step(2'b11, 1, 1, 1, 0, 2'b11);
    check("R6", fault_cause_o, 1, "upper outranks lower");
    cur_req = "R7";
    idle(2'b11, 3);

    // R8: clear beats a simultaneous violation, then re-arm
    cur_req = "R8";
    step(2'b11, 1, 0, 0, 1, 2'b11);
    check("R8", fault_req_o, 0, "clear wins");
    step(2'b10, 1, 0, 0, 1, 2'b11);
    check("R8", fault_req_o, 0, "clear wins again");
    cur_req = "R3";
    step(2'b10, 1, 0, 0, 0, 2'b11);
    check("R3", fault_req_o, 1, "re-armed upper trip");

    // mixed pattern sweep
    cur_req = "R7";
    for (int k = 0; k < 200; k++)
      step(k[3:2], k % 7 == 3, k % 5 == 1, k % 3 == 0, k % 17 == 0, k[1:0]);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule